// File: doc/BRIEF.md
# Two-Write Serial Configuration Loader

This block builds a 24-bit configuration word for an external, digitally controlled device when the host can only write 16 bits at a time. The host makes two register writes into a shadow register. A write with the select low fills the upper 16 bits. A write with the select high fills the lower 8 bits. Neither write sends anything to the device. In the default word layout the device's 1024-step position value takes up a 10-bit field of the 24 bits. The loader does not interpret that field.

A separate one-cycle `update` strobe copies the shadow word into a shift register and starts a framed serial transfer. The sequencer drives chip-select low and holds two setup cycles. It then shifts all 24 bits out, most significant bit first, on a divided serial clock. It holds two cycles after the final edge, releases chip-select and pulses `done` for one cycle.

The sequencer has six states: `LD_IDLE`, `LD_LEAD`, `LD_HIGH`, `LD_LOW`, `LD_TRAIL` and `LD_DONE`. Its transitions are:
- IDLE→LEAD when an update arrives.
- LEAD→HIGH when the setup count ends.
- HIGH→LOW when a half period ends and bits remain. This is the falling edge, and the next bit is presented on it.
- HIGH→TRAIL when the half period of the last bit ends.
- LOW→HIGH when a half period ends.
- TRAIL→DONE when the hold count ends.
- DONE→IDLE unconditionally.

Top module: `cfgword_loader`

## Requirements
- R1: While reset is held, `cs_n`=1, `sclk`=0, `sdata`=0, `busy`=0 and `done`=0.
- R2: A write with `wr_sel`=0 loads `wr_data[15:0]` into word bits 23:8. A write with `wr_sel`=1 loads `wr_data[7:0]` into word bits 7:0. In the second case `wr_data[15:8]` is ignored. Each write leaves the other part of the word unchanged.
- R3: Writes alone never start a transfer. In the cycle after `update` is sampled while idle, `cs_n` is 0 and `busy` is 1. `busy` is 1 whenever `cs_n` is 0.
- R4: Each transfer carries the shadow word as it was when `update` was taken. The device sees it as 24 bits sampled on rising `sclk` edges, bit 23 first.
- R5: `sdata` never changes while `sclk` is high, and it never changes in the cycle where `sclk` rises. It changes only together with a falling edge, or while the serial clock is idle.
- R6: Each transfer has exactly 24 rising edges. Every high and every low phase between them lasts DIV/2 system cycles.
- R7: `sclk` is high only while `cs_n` is 0. `cs_n` is low for exactly CS_SETUP (2) cycles before the first rising edge. It returns high CS_HOLD (2) cycles after the last falling edge. That gives 2 + 23·DIV + DIV/2 + 2 low cycles per transfer.
- R8: `done` is high for exactly one cycle, in the cycle where `cs_n` returns high. `busy` is still 1 in that cycle and 0 in the next.
- R9: An `update` that arrives while `busy` is 1 is ignored. The current transfer is unchanged and no second transfer follows.
- R10: Writes made during a transfer do not alter it. The next update sends the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = upper 16 bits, 1 = lower 8 bits |
| wr_data | input | 16 | Write data |
| update | input | 1 | Start-transfer strobe |
| cs_n | output | 1 | Device chip-select, active low |
| sclk | output | 1 | Serial clock, idles low |
| sdata | output | 1 | Serial data, MSB first |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions assume the following about the inputs:
- `update` and `wr_en` are synchronous to `clk`.
- DIV is even and at least 2.
- The host never expects a strobe to be queued while `busy` is high.

The bench drives every input on the falling clock edge, so those inputs are stable around each rising edge. It sends walking-one words and several dense patterns through a configuration with DIV=4. It fills the unused upper byte of every lower-half write with junk. One transfer carries an overlapping update and an overlapping write, placed well inside the frame where busy is known to be high.

// File: rtl/cfgload_pkg.sv
package cfgload_pkg;
    typedef enum logic [2:0] {
        LD_IDLE,
        LD_LEAD,
        LD_HIGH,
        LD_LOW,
        LD_TRAIL,
        LD_DONE
    } ld_state_e;
endpackage

// File: rtl/cfgload_shadow.sv
module cfgload_shadow #(
    parameter int PORT_W = 16,
    parameter int HI_W   = 16,
    parameter int LO_W   = 8,
    localparam int WORD_W = HI_W + LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [PORT_W-1:0] wr_data,
    output logic [WORD_W-1:0] word
);
    logic [HI_W-1:0] hi_q;
    logic [LO_W-1:0] lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (wr_en && !wr_sel) begin
            hi_q <= wr_data[HI_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else if (wr_en && wr_sel) begin
            lo_q <= wr_data[LO_W-1:0];
        end
    end

    assign word = {hi_q, lo_q};

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(word)); // R2
    AST_LOW_WRITE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (word[WORD_W-1:LO_W] == $past(word[WORD_W-1:LO_W]))); // R2
    AST_HIGH_WRITE_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> (word[LO_W-1:0] == $past(word[LO_W-1:0]))); // R2
endmodule

// File: rtl/cfgload_phase.sv
module cfgload_phase #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = (cnt == limit);

    AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= limit); // R6
endmodule

// File: rtl/cfgload_shifter.sv
module cfgload_shifter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= load_val;
        end else if (shift) begin
            sreg <= {sreg[W-2:0], 1'b0};
        end
    end

    assign msb = sreg[W-1];

    AST_LOAD_SHIFT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift)); // R4
endmodule

// File: rtl/cfgload_seq.sv
module cfgload_seq
    import cfgload_pkg::*;
#(
    parameter int WORD_W   = 24,
    parameter int HALF     = 4,
    parameter int CS_SETUP = 2,
    parameter int CS_HOLD  = 2,
    parameter int CNT_W    = 3,
    localparam int BIT_W   = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             update,
    input  logic             expire,
    output logic             restart,
    output logic [CNT_W-1:0] limit,
    output logic             load,
    output logic             shift,
    output logic             cs_n,
    output logic             sclk,
    output logic             busy,
    output logic             done
);
    ld_state_e state, nxt;
    logic [BIT_W-1:0] bit_idx;
    logic last_bit;

    assign last_bit = (bit_idx == BIT_W'(WORD_W - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LD_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx <= '0;
        end else if (load) begin
            bit_idx <= '0;
        end else if (shift) begin
            bit_idx <= bit_idx + 1'b1;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            LD_IDLE:  if (update) nxt = LD_LEAD;
            LD_LEAD:  if (expire) nxt = LD_HIGH;
            LD_HIGH:  if (expire) nxt = last_bit ? LD_TRAIL : LD_LOW;
            LD_LOW:   if (expire) nxt = LD_HIGH;
            LD_TRAIL: if (expire) nxt = LD_DONE;
            LD_DONE:  nxt = LD_IDLE;
            default:  nxt = LD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cs_n    = 1'b0;
        sclk    = 1'b0;
        busy    = 1'b1;
        done    = 1'b0;
        load    = 1'b0;
        shift   = 1'b0;
        limit   = '0;
        restart = expire;
        unique case (state)
            LD_IDLE: begin
                cs_n    = 1'b1;
                busy    = 1'b0;
                restart = 1'b1;
                load    = update;
            end
            LD_LEAD: begin
                limit = CNT_W'(CS_SETUP - 1);
            end
            LD_HIGH: begin
                sclk  = 1'b1;
                limit = CNT_W'(HALF - 1);
                shift = expire && !last_bit;
            end
            LD_LOW: begin
                limit = CNT_W'(HALF - 1);
            end
            LD_TRAIL: begin
                limit = CNT_W'(CS_HOLD - 1);
            end
            LD_DONE: begin
                cs_n = 1'b1;
                done = 1'b1;
            end
            default: begin
                cs_n = 1'b1;
                busy = 1'b0;
            end
        endcase
    end

    AST_SCLK_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n); // R7
    AST_CS_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(cs_n)); // R8
    AST_BUSY_UPDATE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && update) |=> !$rose(state == LD_LEAD)); // R9
    AST_BIT_INDEX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx < BIT_W'(WORD_W)); // R6
endmodule

// File: rtl/cfgword_loader.sv
module cfgword_loader #(
    parameter int PORT_W   = 16,
    parameter int HI_W     = 16,
    parameter int LO_W     = 8,
    parameter int DIV      = 8,
    parameter int CS_SETUP = 2,
    parameter int CS_HOLD  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [PORT_W-1:0] wr_data,
    input  logic              update,
    output logic              cs_n,
    output logic              sclk,
    output logic              sdata,
    output logic              busy,
    output logic              done
);
    localparam int WORD_W = HI_W + LO_W;
    localparam int HALF   = DIV / 2;
    localparam int PH_A   = (HALF > CS_SETUP) ? HALF : CS_SETUP;
    localparam int PH_MAX = (PH_A > CS_HOLD) ? PH_A : CS_HOLD;
    localparam int CNT_W  = $clog2(PH_MAX + 1);

    logic [WORD_W-1:0] word;
    logic              restart, expire, load, shift;
    logic [CNT_W-1:0]  limit;

    cfgload_shadow #(.PORT_W(PORT_W), .HI_W(HI_W), .LO_W(LO_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .word(word)
    );

    cfgload_phase #(.CNT_W(CNT_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .restart(restart), .limit(limit), .expire(expire)
    );

    cfgload_shifter #(.W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(word),
        .shift(shift), .msb(sdata)
    );

    cfgload_seq #(
        .WORD_W(WORD_W), .HALF(HALF), .CS_SETUP(CS_SETUP),
        .CS_HOLD(CS_HOLD), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .update(update), .expire(expire),
        .restart(restart), .limit(limit), .load(load), .shift(shift),
        .cs_n(cs_n), .sclk(sclk), .busy(busy), .done(done)
    );

    AST_SDATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(sdata)); // R5
endmodule

// File: tb/cfgword_loader_test.sv
module cfgword_loader_test;
    localparam int DIV    = 4;
    localparam int HALF   = DIV / 2;
    localparam int CS_EXP = 2 + 23 * DIV + HALF + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_sel = 1'b0, update = 1'b0;
    logic [15:0] wr_data = '0;
    logic cs_n, sclk, sdata, busy, done;

    int total = 0, bad = 0;

    // monitor state
    logic [23:0] cap;
    int rises, cs_low, lead, duty_err, stable_err, done_cnt, hi_run, lo_run;
    logic sclk_q, sdata_q;

    always #10 clk = ~clk;

    cfgword_loader #(.DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .update(update), .cs_n(cs_n), .sclk(sclk),
        .sdata(sdata), .busy(busy), .done(done)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk && sdata != sdata_q) stable_err++;
            if (sclk && !sclk_q) begin
                if (rises == 0) lead = cs_low;
                if (rises > 0 && lo_run != HALF) duty_err++;
                rises++;
                cap = {cap[22:0], sdata};
                hi_run = 1;
            end else if (sclk) begin
                hi_run++;
            end
            if (!sclk && sclk_q) begin
                if (hi_run != HALF) duty_err++;
                lo_run = 1;
            end else if (!sclk) begin
                lo_run++;
            end
            if (!cs_n) cs_low++;
            if (done) done_cnt++;
        end
        sclk_q  = sclk;
        sdata_q = sdata;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [23:0] w);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = w[23:8];
        @(negedge clk);
        wr_sel = 1'b1; wr_data = {~w[7:0] ^ 8'h3C, w[7:0]};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_frame(input logic [23:0] w, input bit poke);
        int n;
        @(posedge clk);
        cap = '0; rises = 0; cs_low = 0; lead = 0; duty_err = 0;
        stable_err = 0; done_cnt = 0; hi_run = 0; lo_run = 0;
        @(negedge clk);
        update = 1'b1;
        @(negedge clk);
        update = 1'b0;
        check(cs_n == 1'b0 && busy == 1'b1, "R3 start", {cs_n, busy}, 2'b01);
        n = 0;
        while (!done && n < 2000) begin
            if (poke && n == 10) begin
                wr_en = 1'b1; wr_sel = 1'b0; wr_data = ~w[23:8]; update = 1'b1;
            end else begin
                wr_en = 1'b0; update = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        wr_en = 1'b0; update = 1'b0;
        check(n < 2000, "R8 done seen", n, 0);
        check(busy == 1'b1 && cs_n == 1'b1, "R8 done cycle", {busy, cs_n}, 2'b11);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R8 after done", {done, busy}, 2'b00);
        repeat (6) @(negedge clk);
        check(cs_n == 1'b1 && done_cnt == 1, poke ? "R9 no second frame" : "R8 single done",
              {cs_n, done_cnt[30:0]}, 32'h80000001);
        @(posedge clk);
        check(cap == w, poke ? "R10 frame unchanged" : "R4 word", cap, w);
        check(rises == 24, "R6 edge count", rises, 24);
        check(duty_err == 0, "R6 phase length", duty_err, 0);
        check(stable_err == 0, "R5 data stable", stable_err, 0);
        check(cs_low == CS_EXP, "R7 cs low cycles", cs_low, CS_EXP);
        check(lead == 2, "R7 setup", lead, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [23:0] w;
        sclk_q = 1'b0; sdata_q = 1'b0;
        repeat (3) @(negedge clk);
        check(cs_n == 1 && sclk == 0 && sdata == 0 && busy == 0 && done == 0,
              "R1 reset", {cs_n, sclk, sdata, busy, done}, 5'b10000);
        rst_n = 1'b1;
        // R2/R3: writes alone do not start a transfer
        write_word(24'h5A3C96);
        repeat (4) @(negedge clk);
        check(cs_n == 1'b1 && busy == 1'b0, "R3 write no start", {cs_n, busy}, 2'b10);
        run_frame(24'h5A3C96, 1'b0);
        // R2: partial writes keep the other part
        @(negedge clk); wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'hFF81;
        @(negedge clk); wr_en = 1'b0;
        run_frame(24'h5A3C81, 1'b0); // R2 low only
        @(negedge clk); wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'h1234;
        @(negedge clk); wr_en = 1'b0;
        run_frame(24'h123481, 1'b0); // R2 high only
        // R4: walking ones over every bit position
        for (int i = 0; i < 24; i++) begin
            w = 24'h1 << i;
            write_word(w);
            run_frame(w, 1'b0);
        end
        foreach (w[k]) begin end
        w = 24'h000000; write_word(w); run_frame(w, 1'b0);
        w = 24'hFFFFFF; write_word(w); run_frame(w, 1'b0);
        w = 24'hA5C33C; write_word(w); run_frame(w, 1'b0);
        // R9/R10: update and write during a busy frame
        w = 24'h6B1E47; write_word(w); run_frame(w, 1'b1);
        run_frame({~w[23:8], w[7:0]}, 1'b0); // R10 new word goes next
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule